// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block turns the outcome of one ALU operation into the six arithmetic status flags and keeps them in a 32-bit flags word. The ALU supplies both operands, its raw result and two codes. One code gives the operand width (8, 16 or 32 bits). The other gives the operation class: addition, subtraction or logical. On an update strobe the flags are recomputed and written into the word. A separate single-bit command path sets or clears any implemented flag, including a direction control bit that arithmetic never touches.

The raw result is 33 bits wide. It must equal `{1'b0,a}+{1'b0,b}` for addition and `{1'b0,a}-{1'b0,b}` (mod 2^33) for subtraction, with the full 32-bit operands. For logical operations only the low bits of the result matter. The block recovers carry and borrow at any width from this wide value together with the operands.

Top module: `stat_flag_unit`

## Requirements
- R1: After reset the flags word reads 0x00000002. Bit 1 always reads one, and every bit other than 0, 1, 2, 4, 6, 7, 10 and 11 always reads zero.
- R2: With no update strobe and no bit command, the flags word holds its value whatever the data inputs do.
- R3: Carry (bit 0) is set when an addition carries out of the selected width, or when a subtraction borrows (truncated A below truncated B). Width code: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits.
- R4: Parity (bit 2) is set when result bits 7:0 hold an even number of ones, at every width.
- R5: Auxiliary carry (bit 4) is set when an addition carries from bit 3 into bit 4, or when a subtraction borrows across that boundary.
- R6: Zero (bit 6) is set when the width-truncated result is zero. Sign (bit 7) copies the top bit of the width-truncated result. Result bits above the width are ignored.
- R7: Overflow (bit 11) is set when the signed outcome of an addition or subtraction does not fit the selected width.
- R8: Operation code 0 = add, 1 = subtract, 2 or 3 = logical. A logical update clears carry and overflow, keeps auxiliary carry, and updates parity, zero and sign.
- R9: A bit command names a position on `bit_idx_i`. `bit_set_i` forces that bit to one and `bit_clr_i` forces it to zero; set wins when both are high. Only bits 0, 2, 4, 6, 7, 10 and 11 respond; commands to any other position are ignored.
- R10: When a bit command and an update strobe fall in the same cycle, the commanded bit takes the command value and the other flags take the strobe's values.
- R11: Direction (bit 10) changes only through bit commands, never through an update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opnd_a_i | input | 32 | Operand A |
| opnd_b_i | input | 32 | Operand B |
| raw_res_i | input | 33 | Raw wide ALU result |
| op_size_i | input | 2 | Operand width code |
| op_kind_i | input | 2 | Operation class code |
| upd_i | input | 1 | Update strobe for the arithmetic flags |
| bit_set_i | input | 1 | Set the indexed flag bit |
| bit_clr_i | input | 1 | Clear the indexed flag bit |
| bit_idx_i | input | 5 | Flag bit position for a command |
| flags_o | output | 32 | Registered flags word |

## Verification
All state lives in the flags word, and that word is the output, so a wrong internal value is visible on `flags_o` one clock after the edge that caused it. The scoreboard compares the whole word after every cycle, idle cycles included. A stray write, a lost direction bit or a reserved bit that drifts therefore fails at the first cycle where it happens. Carry and overflow recovery at each width is exercised with operands whose upper bits hold unrelated data, so that a wrong bit selection shows up at once.

// File: rtl/stat_flag_pkg.sv
package stat_flag_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FLAG_W = 32;
  localparam int unsigned PAR_W  = 8;
  localparam int unsigned IDX_W  = $clog2(FLAG_W);
  localparam int unsigned AUX_B  = 4;

  localparam int unsigned CF_POS = 0;
  localparam int unsigned RS_POS = 1;
  localparam int unsigned PF_POS = 2;
  localparam int unsigned AF_POS = 4;
  localparam int unsigned ZF_POS = 6;
  localparam int unsigned SF_POS = 7;
  localparam int unsigned DF_POS = 10;
  localparam int unsigned OF_POS = 11;

  localparam logic [FLAG_W-1:0] RESET_VAL = FLAG_W'(1) << RS_POS;
  localparam logic [FLAG_W-1:0] WR_MASK =
      (FLAG_W'(1) << CF_POS) | (FLAG_W'(1) << PF_POS) | (FLAG_W'(1) << AF_POS) |
      (FLAG_W'(1) << ZF_POS) | (FLAG_W'(1) << SF_POS) | (FLAG_W'(1) << DF_POS) |
      (FLAG_W'(1) << OF_POS);

  typedef enum logic [1:0] {
    OP_ADD = 2'd0, OP_SUB = 2'd1, OP_LOGIC = 2'd2, OP_LOGIC_ALT = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD_ALT = 2'd3
  } op_size_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } arith_flags_t;
endpackage

// File: rtl/stat_flag_parity.sv
module stat_flag_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         even_o
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_x
    assign chain[i+1] = chain[i] ^ d_i[i];
  end
  assign even_o = ~chain[W];
endmodule

// File: rtl/stat_flag_calc.sv
module stat_flag_calc
  import stat_flag_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W:0]   res_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        kind_i,
  output arith_flags_t      flags_o,
  output logic              logic_op_o
);
  localparam int unsigned MSB_W = $clog2(DATA_W) + 1;

  op_kind_e          kind;
  logic [MSB_W-1:0]  msb;
  logic [DATA_W:0]   a_x, b_x;
  logic [DATA_W-1:0] mask, res_t;
  logic              carry_n, aux_c, sa, sb, sr, ovf, par_even;

  assign kind = op_kind_e'(kind_i);
  assign a_x  = {1'b0, a_i};
  assign b_x  = {1'b0, b_i};

  always_comb begin
    unique case (op_size_e'(size_i))
      SZ_BYTE: msb = MSB_W'(7);
      SZ_HALF: msb = MSB_W'(15);
      default: msb = MSB_W'(DATA_W - 1);
    endcase
  end

  assign mask  = {DATA_W{1'b1}} >> (MSB_W'(DATA_W - 1) - msb);
  assign res_t = res_i[DATA_W-1:0] & mask;

  // carry/borrow into bit msb+1 recovered from sum bit identity
  assign carry_n = res_i[msb + 1'b1] ^ a_x[msb + 1'b1] ^ b_x[msb + 1'b1];
  assign aux_c   = res_i[AUX_B] ^ a_i[AUX_B] ^ b_i[AUX_B];

  assign sa = a_i[msb[MSB_W-2:0]];
  assign sb = b_i[msb[MSB_W-2:0]];
  assign sr = res_i[msb[MSB_W-2:0]];

  always_comb begin
    unique case (kind)
      OP_ADD:  ovf = (sa == sb) && (sr != sa);
      OP_SUB:  ovf = (sa != sb) && (sr != sa);
      default: ovf = 1'b0;
    endcase
  end

  stat_flag_parity #(.W(PAR_W)) u_par (
    .d_i   (res_t[PAR_W-1:0]),
    .even_o(par_even)
  );

  assign logic_op_o = (kind == OP_LOGIC) || (kind == OP_LOGIC_ALT);

  always_comb begin
    flags_o.cf = logic_op_o ? 1'b0 : carry_n;
    flags_o.of = ovf;
    flags_o.af = aux_c;
    flags_o.pf = par_even;
    flags_o.zf = (res_t == '0);
    flags_o.sf = sr;
  end
endmodule

// File: rtl/stat_flag_reg.sv
module stat_flag_reg
  import stat_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  arith_flags_t      next_i,
  input  logic              keep_af_i,
  input  logic              bit_set_i,
  input  logic              bit_clr_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic cmd;
  assign cmd = bit_set_i | bit_clr_i;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (WR_MASK[i]) begin : g_wr
      logic nv, en, hit, bit_q;
      if (i == CF_POS) begin : g_cf
        assign nv = next_i.cf; assign en = 1'b1;
      end else if (i == PF_POS) begin : g_pf
        assign nv = next_i.pf; assign en = 1'b1;
      end else if (i == AF_POS) begin : g_af
        assign nv = next_i.af; assign en = ~keep_af_i;
      end else if (i == ZF_POS) begin : g_zf
        assign nv = next_i.zf; assign en = 1'b1;
      end else if (i == SF_POS) begin : g_sf
        assign nv = next_i.sf; assign en = 1'b1;
      end else if (i == OF_POS) begin : g_of
        assign nv = next_i.of; assign en = 1'b1;
      end else begin : g_ctl
        assign nv = 1'b0; assign en = 1'b0;
      end
      assign hit = cmd && (bit_idx_i == IDX_W'(i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              bit_q <= RESET_VAL[i];
        else if (hit)             bit_q <= bit_set_i;
        else if (upd_i && en)     bit_q <= nv;
      end
      assign flags_o[i] = bit_q;
    end else begin : g_fix
      assign flags_o[i] = RESET_VAL[i];
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !cmd) |=> $stable(flags_o));

  assert_dir_only_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd && bit_idx_i == IDX_W'(DF_POS)) |=> $stable(flags_o[DF_POS]));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_set_i && WR_MASK[bit_idx_i]) |=> flags_o[$past(bit_idx_i)]);

  assert_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_clr_i && !bit_set_i && WR_MASK[bit_idx_i]) |=> !flags_o[$past(bit_idx_i)]);
endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
  import stat_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [DATA_W:0]   raw_res_i,
  input  logic [1:0]        op_size_i,
  input  logic [1:0]        op_kind_i,
  input  logic              upd_i,
  input  logic              bit_set_i,
  input  logic              bit_clr_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  output logic [FLAG_W-1:0] flags_o
);
  arith_flags_t nxt;
  logic         is_logic;

  stat_flag_calc u_calc (
    .a_i       (opnd_a_i),
    .b_i       (opnd_b_i),
    .res_i     (raw_res_i),
    .size_i    (op_size_i),
    .kind_i    (op_kind_i),
    .flags_o   (nxt),
    .logic_op_o(is_logic)
  );

  stat_flag_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd_i),
    .next_i   (nxt),
    .keep_af_i(is_logic),
    .bit_set_i(bit_set_i),
    .bit_clr_i(bit_clr_i),
    .bit_idx_i(bit_idx_i),
    .flags_o  (flags_o)
  );

  logic cmd_any;
  assign cmd_any = bit_set_i | bit_clr_i;

  assert_logic_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_kind_i[1] && !cmd_any) |=> (!flags_o[CF_POS] && !flags_o[OF_POS]));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !cmd_any && op_kind_i == 2'd0 && op_size_i == 2'd0 &&
     opnd_a_i[7] != opnd_b_i[7]) |=> !flags_o[OF_POS]);

  assert_logic_keeps_af_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_kind_i[1] && !cmd_any) |=> $stable(flags_o[AF_POS]));
endmodule

// File: tb/stat_flag_unit_tb_top.sv
module stat_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [32:0] res = '0;
  logic [1:0]  sz = '0, kind = '0;
  logic        upd = 1'b0, bset = 1'b0, bclr = 1'b0;
  logic [4:0]  idx = '0;
  logic [31:0] flags;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  logic [31:0] model = 32'h2;

  always #5 clk = ~clk;

  stat_flag_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opnd_a_i(a), .opnd_b_i(b), .raw_res_i(res),
    .op_size_i(sz), .op_kind_i(kind), .upd_i(upd), .bit_set_i(bset),
    .bit_clr_i(bclr), .bit_idx_i(idx), .flags_o(flags)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: flags=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(flags, it.exp, it.tag);
    end
  end

  task automatic drive(input logic [31:0] ta, input logic [31:0] tb, input logic [1:0] tsz,
                       input logic [1:0] tk, input logic tu, input logic ts,
                       input logic tc, input logic [4:0] ti, input string tag);
    int unsigned n;
    logic [32:0] m, at, bt, s, rt;
    logic cf, af, of, sa, sb;
    item_t it;
    @(negedge clk);
    n  = (tsz == 2'd0) ? 8 : (tsz == 2'd1) ? 16 : 32;
    m  = (33'd1 << n) - 33'd1;
    at = {1'b0, ta} & m;
    bt = {1'b0, tb} & m;
    sa = at[n-1];
    sb = bt[n-1];
    cf = 1'b0; af = model[4]; of = 1'b0;
    if (tk == 2'd0) begin
      res = {1'b0, ta} + {1'b0, tb};
      s   = at + bt;
      cf  = s[n];
      rt  = s & m;
      af  = ({28'd0, ta[3:0]} + {28'd0, tb[3:0]}) > 32'd15;
      of  = (sa == sb) && (rt[n-1] != sa);
    end else if (tk == 2'd1) begin
      res = {1'b0, ta} - {1'b0, tb};
      cf  = at < bt;
      rt  = (at - bt) & m;
      af  = ta[3:0] < tb[3:0];
      of  = (sa != sb) && (rt[n-1] != sa);
    end else begin
      res = {1'b0, ta & tb};
      rt  = {1'b0, ta & tb} & m;
    end
    a = ta; b = tb; sz = tsz; kind = tk; upd = tu; bset = ts; bclr = tc; idx = ti;
    if (tu) begin
      model[0]  = cf;
      model[2]  = ~^rt[7:0];
      model[4]  = af;
      model[6]  = (rt == 33'd0);
      model[7]  = rt[n-1];
      model[11] = of;
    end
    if ((ts || tc) && (ti inside {5'd0, 5'd2, 5'd4, 5'd6, 5'd7, 5'd10, 5'd11}))
      model[ti] = ts;
    it.exp = model;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic op(input logic [31:0] ta, input logic [31:0] tb, input logic [1:0] tsz,
                    input logic [1:0] tk, input string tag);
    drive(ta, tb, tsz, tk, 1'b1, 1'b0, 1'b0, 5'd0, tag);
  endtask

  task automatic cmd(input logic ts, input logic tc, input logic [4:0] ti, input string tag);
    drive(32'hDEAD_BEEF, 32'h1234_5678, 2'd2, 2'd0, 1'b0, ts, tc, ti, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: flags=%08h expected=idle", flags);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    check(flags, 32'h2, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(flags, 32'h2, "R1 after release");

    drive(32'hFFFF_FFFF, 32'h1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0, "R2 idle");
    op(32'h0000_00FF, 32'h0000_0001, 2'd0, 2'd0, "R3 byte add carry");
    op(32'h0000_0000, 32'h0000_0001, 2'd0, 2'd1, "R3 byte sub borrow");
    op(32'hAB00_007F, 32'h0000_0001, 2'd0, 2'd0, "R7 byte add ovf");
    op(32'h0000_8000, 32'h0000_0001, 2'd1, 2'd1, "R7 half sub ovf");
    op(32'h8000_0000, 32'h8000_0000, 2'd2, 2'd0, "R7 word add ovf carry");
    op(32'hFFFF_FFFF, 32'h0000_0001, 2'd3, 2'd0, "R3 word add carry zero");
    op(32'h1234_0001, 32'h5678_FFFF, 2'd1, 2'd0, "R6 half trunc zero");
    op(32'h0000_0103, 32'h0000_0000, 2'd2, 2'd0, "R4 parity even");
    op(32'h0000_0107, 32'h0000_0000, 2'd2, 2'd0, "R4 parity odd");
    op(32'h0000_0008, 32'h0000_0008, 2'd0, 2'd0, "R5 aux add");
    op(32'h0000_0010, 32'h0000_0001, 2'd1, 2'd1, "R5 aux sub");
    op(32'hF0F0_80FF, 32'hFFFF_8081, 2'd1, 2'd2, "R8 logical keeps aux");
    op(32'h0000_0000, 32'hFFFF_FFFF, 2'd2, 2'd3, "R8 logical alt zero");
    cmd(1'b1, 1'b0, 5'd10, "R11 set direction");
    op(32'h0000_00FF, 32'h0000_0001, 2'd0, 2'd0, "R11 add keeps direction");
    cmd(1'b1, 1'b0, 5'd20, "R9 unimplemented bit ignored");
    cmd(1'b0, 1'b1, 5'd1, "R9 reserved bit stays one");
    cmd(1'b1, 1'b1, 5'd7, "R9 set wins");
    cmd(1'b0, 1'b1, 5'd10, "R11 clear direction");
    drive(32'h0000_00FF, 32'h0000_0001, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 5'd0, "R10 cmd over strobe");
    drive(32'h0000_0001, 32'h0000_0001, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 5'd6, "R10 set zero on add");
    drive(32'h0000_0000, 32'h0000_0000, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 5'd0, "R2 idle hold");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; ra = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; rb = lfsr;
      if (i % 7 == 0) rb = ra;
      drive(ra, rb, 2'(i % 4), 2'(i / 4 % 4), (i % 5) != 0, (i % 11) == 0, (i % 13) == 0,
            5'(ra[4:0]), "R6 mixed");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule